// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command and status side of a NOR-style flash device. A host writes command bytes over an asynchronous bus made of two active-low chip enables, a write enable and an output enable. The block samples that bus on its own clock and treats a rising write enable, while both chips are enabled, as one command write. The commands choose one of four read views (array, query, identifier, status). They also start program, block erase and lock-bit operations.

A modelled write state machine runs each operation for a fixed, parameterised number of cycles. Per-block lock bits refuse program and erase on a protected block. An 8-bit status register carries a ready flag, suspend flags and sticky error flags. A ready/busy pin shows whether an operation is running. Program and erase can be suspended and resumed without losing progress.

An active-low reset pin doubles as deep power-down. It aborts any operation, floats the outputs, restores the read-array view and sets the status to 80h. For a few cycles after release, writes are refused. The array storage is external: the block presents a word address and passes the array word through. It shapes every read to 16-bit or 8-bit width.

Top module: `flashCmdIf`

## Requirements
- R1: Command bytes select the read view: FFh array (the arrayData word), 98h query (parameter QUERY_WORD), 90h identifier, 70h status (status byte in bits 7:0, bits 15:8 zero). In the identifier view the word offset addr[2:1] gives 0 → MFR_ID, 1 → DEV_ID, 2 → lock bit of the addressed block in bit 0, 3 → zero.
- R2: With wordMode high the full 16-bit value is returned and addr[0] has no effect. With wordMode low, bits 7:0 carry the low byte (addr[0]=0) or the high byte (addr[0]=1), and bits 15:8 are zero. arrayAddr is always addr[ADDR_W-1:1].
- R3: dataOe is high only when ceA_n, ceB_n and oe_n are all low and we_n and rp_n are high. While dataOe is low, dataOut is zero.
- R4: While rp_n is low, readyBusy is high, dataOe is low and any running operation is dropped. After release the view is array and the status reads 80h.
- R5: Command writes whose strobe falls in the first WAKE_CYCLES clock edges after rp_n rises are ignored.
- R6: 40h followed by any data write starts a program of the block addressed by the second write. readyBusy is low for exactly PGM_CYCLES cycles and status bit 7 is 0 during that time. Setup commands switch the view to status.
- R7: 20h followed by D0h starts a block erase lasting ERASE_CYCLES cycles. Any other second byte starts nothing and sets status bit 5.
- R8: 60h followed by 01h sets the lock bit of the addressed block (block = top BLOCK_BITS address bits). 60h followed by D0h clears all lock bits. Each takes LOCK_CYCLES cycles, and lock bits survive rp_n.
- R9: A program on a locked block does not start and sets status bits 4 and 1. An erase on a locked block does not start and sets bits 5 and 1. In both cases ready stays high.
- R10: Error bits 5, 4 and 1 stay set until 50h is written, which clears them.
- R11: B0h during a running program or erase pauses it: readyBusy goes high, bit 7 reads 1, and bit 6 (erase) or bit 2 (program) is set. D0h resumes it, and the total busy time still equals the full count.
- R12: While an operation runs, only 70h and B0h are accepted. While suspended, only view commands, 50h and D0h are accepted.
- R13: An operation keeps running to completion while the chip enables are high.
- R14: readyBusy is low exactly while an operation runs and is not suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and state-machine clock |
| rp_n | input | 1 | Active-low reset / deep power-down |
| ceA_n | input | 1 | Chip enable A, active low |
| ceB_n | input | 1 | Chip enable B, active low |
| we_n | input | 1 | Write enable, active low; rising edge latches a write |
| oe_n | input | 1 | Output enable, active low |
| wordMode | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| addr | input | ADDR_W | Byte address |
| cmdData | input | 8 | Command / data byte of a write |
| arrayData | input | 16 | Word returned by the external array |
| arrayAddr | output | ADDR_W-1 | Word address to the external array |
| dataOut | output | 16 | Read data |
| dataOe | output | 1 | Read data drive enable |
| readyBusy | output | 1 | High when ready, low while an operation runs |

## Verification
A wrong countdown or freeze shows up directly as a busy window of the wrong length on readyBusy, measured in whole cycles from the accepting strobe. A stuck pending-setup state, lost suspend flag or missed error flag shows on the next status read, one bus read after the write that caused it. Lock-bit corruption appears in the identifier view and in the status of the next program to that block. A wrong view or byte-lane selection appears on dataOut within the same read.

// File: rtl/flashPkg.sv
package flashPkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_QUERY  = 2'd1,
    RD_IDENT  = 2'd2,
    RD_STATUS = 2'd3
  } readMode_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PGM   = 2'd1,
    OP_ERASE = 2'd2,
    OP_LOCK  = 2'd3
  } op_e;

  // Control-to-datapath bundle
  typedef struct packed {
    readMode_e  mode;
    logic [7:0] status;
    logic       addrLocked;
  } ctlToDp_t;

  localparam logic [7:0] CMD_VIEW_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_VIEW_QUERY  = 8'h98;
  localparam logic [7:0] CMD_VIEW_IDENT  = 8'h90;
  localparam logic [7:0] CMD_VIEW_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_PGM_SETUP   = 8'h40;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_LOCK_SETUP  = 8'h60;
  localparam logic [7:0] CMD_LOCK_SET    = 8'h01;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

endpackage

// File: rtl/flashCtl.sv
module flashCtl
  import flashPkg::*;
#(
  parameter int BLOCK_BITS   = 2,
  parameter int PGM_CYCLES   = 5,
  parameter int ERASE_CYCLES = 12,
  parameter int LOCK_CYCLES  = 3,
  parameter int WAKE_CYCLES  = 4
) (
  input  logic                  clk,
  input  logic                  rp_n,
  input  logic                  ceA_n,
  input  logic                  ceB_n,
  input  logic                  we_n,
  input  logic [BLOCK_BITS-1:0] blkIdx,
  input  logic [7:0]            cmd,
  output ctlToDp_t              ctl,
  output logic                  readyBusy
);

  localparam int NUM_BLOCKS = 1 << BLOCK_BITS;
  localparam int CNT_MAX    = (ERASE_CYCLES > PGM_CYCLES)
                              ? ((ERASE_CYCLES > LOCK_CYCLES) ? ERASE_CYCLES : LOCK_CYCLES)
                              : ((PGM_CYCLES > LOCK_CYCLES) ? PGM_CYCLES : LOCK_CYCLES);
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int WAKE_W     = $clog2(WAKE_CYCLES + 1);

  logic                  wePrev;
  logic [WAKE_W-1:0]     wakeCnt;
  readMode_e             mode;
  op_e                   pend;
  op_e                   op;
  logic                  busy;
  logic                  susp;
  logic [CNT_W-1:0]      cnt;
  logic                  lockSet;
  logic [BLOCK_BITS-1:0] lockBlk;
  logic                  errErase;
  logic                  errPgm;
  logic                  errLock;
  logic [NUM_BLOCKS-1:0] lockBits = '0;

  logic wrStb;
  logic running;
  logic tgtLocked;
  logic lockCommit;

  assign wrStb      = we_n && !wePrev && !ceA_n && !ceB_n && (wakeCnt == '0);
  assign running    = busy && !susp;
  assign tgtLocked  = lockBits[blkIdx];
  assign lockCommit = running && (op == OP_LOCK) && (cnt == '0);

  always_ff @(posedge clk or negedge rp_n) begin
    if (!rp_n) begin
      wePrev   <= 1'b1;
      wakeCnt  <= WAKE_W'(WAKE_CYCLES);
      mode     <= RD_ARRAY;
      pend     <= OP_NONE;
      op       <= OP_NONE;
      busy     <= 1'b0;
      susp     <= 1'b0;
      cnt      <= '0;
      lockSet  <= 1'b0;
      lockBlk  <= '0;
      errErase <= 1'b0;
      errPgm   <= 1'b0;
      errLock  <= 1'b0;
    end else begin
      wePrev <= we_n;
      if (wakeCnt != '0) wakeCnt <= wakeCnt - 1'b1;

      if (running) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end

      if (wrStb) begin
        if (running) begin
          if (cmd == CMD_VIEW_STATUS) mode <= RD_STATUS;
          else if (cmd == CMD_SUSPEND && op != OP_LOCK && cnt != '0) begin
            susp <= 1'b1;
            mode <= RD_STATUS;
          end
        end else if (pend != OP_NONE) begin
          pend <= OP_NONE;
          mode <= RD_STATUS;
          unique case (pend)
            OP_PGM: begin
              if (tgtLocked) begin
                errPgm  <= 1'b1;
                errLock <= 1'b1;
              end else begin
                busy <= 1'b1;
                op   <= OP_PGM;
                cnt  <= CNT_W'(PGM_CYCLES - 1);
              end
            end
            OP_ERASE: begin
              if (cmd != CMD_CONFIRM) errErase <= 1'b1;
              else if (tgtLocked) begin
                errErase <= 1'b1;
                errLock  <= 1'b1;
              end else begin
                busy <= 1'b1;
                op   <= OP_ERASE;
                cnt  <= CNT_W'(ERASE_CYCLES - 1);
              end
            end
            OP_LOCK: begin
              if (cmd == CMD_LOCK_SET || cmd == CMD_CONFIRM) begin
                busy    <= 1'b1;
                op      <= OP_LOCK;
                cnt     <= CNT_W'(LOCK_CYCLES - 1);
                lockSet <= (cmd == CMD_LOCK_SET);
                lockBlk <= blkIdx;
              end
            end
            default: ;
          endcase
        end else begin
          case (cmd)
            CMD_VIEW_ARRAY:  mode <= RD_ARRAY;
            CMD_VIEW_QUERY:  mode <= RD_QUERY;
            CMD_VIEW_IDENT:  mode <= RD_IDENT;
            CMD_VIEW_STATUS: mode <= RD_STATUS;
            CMD_CLR_STATUS: begin
              errErase <= 1'b0;
              errPgm   <= 1'b0;
              errLock  <= 1'b0;
            end
            CMD_CONFIRM: begin
              if (susp) begin
                susp <= 1'b0;
                mode <= RD_STATUS;
              end
            end
            CMD_PGM_SETUP: if (!busy) begin
              pend <= OP_PGM;
              mode <= RD_STATUS;
            end
            CMD_ERASE_SETUP: if (!busy) begin
              pend <= OP_ERASE;
              mode <= RD_STATUS;
            end
            CMD_LOCK_SETUP: if (!busy) begin
              pend <= OP_LOCK;
              mode <= RD_STATUS;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // Non-volatile lock bits: untouched by the reset pin
  always_ff @(posedge clk) begin
    if (lockCommit) begin
      if (lockSet) lockBits[lockBlk] <= 1'b1;
      else         lockBits          <= '0;
    end
  end

  assign readyBusy      = !running;
  assign ctl.mode       = mode;
  assign ctl.addrLocked = tgtLocked;
  assign ctl.status     = {!busy || susp,
                           susp && (op == OP_ERASE),
                           errErase,
                           errPgm,
                           1'b0,
                           susp && (op == OP_PGM),
                           errLock,
                           1'b0};

  assert_wake_quiet_R5: assert property (@(posedge clk) disable iff (!rp_n)
    (wakeCnt != '0) |=> $stable(mode) && $stable(pend));

  assert_suspend_freeze_R11: assert property (@(posedge clk) disable iff (!rp_n)
    (busy && susp) |=> $stable(cnt));

  assert_suspend_needs_op_R11: assert property (@(posedge clk) disable iff (!rp_n)
    susp |-> busy);

  assert_locked_no_start_R9: assert property (@(posedge clk) disable iff (!rp_n)
    (wrStb && !busy && (pend == OP_PGM || pend == OP_ERASE) && tgtLocked) |=> !busy);

  assert_count_holds_busy_R6: assert property (@(posedge clk) disable iff (!rp_n)
    (running && cnt != '0) |=> busy);

endmodule

// File: rtl/flashDp.sv
module flashDp
  import flashPkg::*;
#(
  parameter logic [15:0] MFR_ID     = 16'h00A5,
  parameter logic [15:0] DEV_ID     = 16'h5A3C,
  parameter logic [15:0] QUERY_WORD = 16'h7E51
) (
  input  logic        clk,
  input  logic        rp_n,
  input  ctlToDp_t    ctl,
  input  logic        ceA_n,
  input  logic        ceB_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic        wordMode,
  input  logic [2:0]  addrLo,
  input  logic [15:0] arrayData,
  output logic [15:0] dataOut,
  output logic        dataOe
);

  logic [15:0] rawWord;
  logic [15:0] shaped;

  always_comb begin
    unique case (ctl.mode)
      RD_ARRAY:  rawWord = arrayData;
      RD_QUERY:  rawWord = QUERY_WORD;
      RD_IDENT: begin
        case (addrLo[2:1])
          2'd0:    rawWord = MFR_ID;
          2'd1:    rawWord = DEV_ID;
          2'd2:    rawWord = {15'd0, ctl.addrLocked};
          default: rawWord = '0;
        endcase
      end
      default:   rawWord = {8'h00, ctl.status};
    endcase
  end

  assign shaped  = wordMode ? rawWord
                            : {8'h00, (addrLo[0] ? rawWord[15:8] : rawWord[7:0])};
  assign dataOe  = rp_n && !ceA_n && !ceB_n && !oe_n && we_n;
  assign dataOut = dataOe ? shaped : '0;

  assert_status_upper_zero_R1: assert property (@(posedge clk) disable iff (!rp_n)
    (dataOe && ctl.mode == RD_STATUS) |-> (dataOut[15:8] == 8'h00));

endmodule

// File: rtl/flashCmdIf.sv
module flashCmdIf
  import flashPkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          BLOCK_BITS   = 2,
  parameter int          PGM_CYCLES   = 5,
  parameter int          ERASE_CYCLES = 12,
  parameter int          LOCK_CYCLES  = 3,
  parameter int          WAKE_CYCLES  = 4,
  parameter logic [15:0] MFR_ID       = 16'h00A5,
  parameter logic [15:0] DEV_ID       = 16'h5A3C,
  parameter logic [15:0] QUERY_WORD   = 16'h7E51
) (
  input  logic              clk,
  input  logic              rp_n,
  input  logic              ceA_n,
  input  logic              ceB_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              wordMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cmdData,
  input  logic [15:0]       arrayData,
  output logic [ADDR_W-2:0] arrayAddr,
  output logic [15:0]       dataOut,
  output logic              dataOe,
  output logic              readyBusy
);

  ctlToDp_t ctl;

  assign arrayAddr = addr[ADDR_W-1:1];

  flashCtl #(
    .BLOCK_BITS  (BLOCK_BITS),
    .PGM_CYCLES  (PGM_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES),
    .LOCK_CYCLES (LOCK_CYCLES),
    .WAKE_CYCLES (WAKE_CYCLES)
  ) ctlInst (
    .clk      (clk),
    .rp_n     (rp_n),
    .ceA_n    (ceA_n),
    .ceB_n    (ceB_n),
    .we_n     (we_n),
    .blkIdx   (addr[ADDR_W-1 -: BLOCK_BITS]),
    .cmd      (cmdData),
    .ctl      (ctl),
    .readyBusy(readyBusy)
  );

  flashDp #(
    .MFR_ID    (MFR_ID),
    .DEV_ID    (DEV_ID),
    .QUERY_WORD(QUERY_WORD)
  ) dpInst (
    .clk      (clk),
    .rp_n     (rp_n),
    .ctl      (ctl),
    .ceA_n    (ceA_n),
    .ceB_n    (ceB_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .wordMode (wordMode),
    .addrLo   (addr[2:0]),
    .arrayData(arrayData),
    .dataOut  (dataOut),
    .dataOe   (dataOe)
  );

endmodule

// File: tb/flashCmdIf_test.sv
module flashCmdIf_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int PGM_C = 5;
  localparam int ERASE_C = 12;
  localparam int LOCK_C = 3;
  localparam int WAKE_C = 4;
  localparam logic [15:0] MFR = 16'h00A5;
  localparam logic [15:0] DEV = 16'h5A3C;
  localparam logic [15:0] QRY = 16'h7E51;

  logic clk = 0;
  logic rp_n = 0, ceA_n = 1, ceB_n = 1, we_n = 1, oe_n = 1, wordMode = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] cmdData = '0;
  logic [15:0] arrayData;
  logic [ADDR_W-2:0] arrayAddr;
  logic [15:0] dataOut;
  logic dataOe, readyBusy;

  int checks = 0, failures = 0, lowCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign arrayData = 16'h1357 ^ {arrayAddr, 1'b0, arrayAddr, 1'b1};

  always @(negedge clk) if (!readyBusy) lowCount++;

  flashCmdIf #(.ADDR_W(ADDR_W), .BLOCK_BITS(2), .PGM_CYCLES(PGM_C), .ERASE_CYCLES(ERASE_C),
               .LOCK_CYCLES(LOCK_C), .WAKE_CYCLES(WAKE_C), .MFR_ID(MFR), .DEV_ID(DEV),
               .QUERY_WORD(QRY)) uut (
    .clk(clk), .rp_n(rp_n), .ceA_n(ceA_n), .ceB_n(ceB_n), .we_n(we_n), .oe_n(oe_n),
    .wordMode(wordMode), .addr(addr), .cmdData(cmdData), .arrayData(arrayData),
    .arrayAddr(arrayAddr), .dataOut(dataOut), .dataOe(dataOe), .readyBusy(readyBusy));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; cmdData = d; ceA_n = 0; ceB_n = 0; we_n = 0;
    @(negedge clk);
    we_n = 1;
    @(negedge clk);
    ceA_n = 1; ceB_n = 1;
  endtask

  task automatic probe(input logic [7:0] a, input logic wm, input logic ca, input logic cb,
                       input logic oe, input logic we,
                       output logic [15:0] v, output logic e);
    @(negedge clk);
    addr = a; wordMode = wm; ceA_n = ca; ceB_n = cb; oe_n = oe; we_n = we;
    #1;
    v = dataOut; e = dataOe;
    ceA_n = 1; ceB_n = 1; oe_n = 1;
    #1;
    we_n = 1;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic wm,
                       input logic [15:0] exp);
    logic [15:0] v; logic e;
    probe(a, wm, 0, 0, 0, 1, v, e);
    check(req, {15'd0, e}, 16'd1);
    check(req, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] shape(input logic [15:0] raw, input logic [7:0] a,
                                        input logic wm);
    if (wm) return raw;
    return {8'h00, a[0] ? raw[15:8] : raw[7:0]};
  endfunction

  function automatic logic [15:0] arrModel(input logic [7:0] a);
    logic [6:0] w;
    w = a[7:1];
    return 16'h1357 ^ {w, 1'b0, w, 1'b1};
  endfunction

  function automatic logic [15:0] identModel(input logic [7:0] a, input logic [3:0] locks);
    case (a[2:1])
      2'd0: return MFR;
      2'd1: return DEV;
      2'd2: return {15'd0, locks[a[7:6]]};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic sweepViews(input logic [3:0] locks);
    wr(0, 8'hFF);
    for (int a = 0; a < 16; a++)
      for (int wm = 0; wm < 2; wm++)
        rdChk("R1 R2 array", 8'(a * 17), wm[0], shape(arrModel(8'(a * 17)), 8'(a * 17), wm[0]));
    wr(0, 8'h98);
    for (int a = 0; a < 4; a++)
      for (int wm = 0; wm < 2; wm++)
        rdChk("R1 R2 query", 8'(a), wm[0], shape(QRY, 8'(a), wm[0]));
    wr(0, 8'h90);
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 8; a++)
        for (int wm = 0; wm < 2; wm++)
          rdChk("R1 R8 ident", 8'(b * 64 + a), wm[0],
                shape(identModel(8'(b * 64 + a), locks), 8'(b * 64 + a), wm[0]));
    wr(0, 8'h70);
    rdChk("R1 status", 8'h01, 0, 16'h0000);
    rdChk("R1 status", 8'h00, 1, 16'h0080);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v; logic e; int held;
    idle(3);
    // R4: reset state
    check("R4 readyBusy in reset", {15'd0, readyBusy}, 16'd1);
    probe(8'h06, 1, 0, 0, 0, 1, v, e);
    check("R4 dataOe in reset", {15'd0, e}, 16'd0);
    check("R3 dataOut zero", v, 16'd0);

    // R5: write during wake ignored
    @(negedge clk); rp_n = 1;
    wr(0, 8'h70);
    rdChk("R5 wake ignores write", 8'h06, 1, arrModel(8'h06));
    idle(WAKE_C + 2);
    wr(0, 8'h70);
    rdChk("R4 status after reset", 8'h00, 1, 16'h0080);

    // R3: output enable conditions
    probe(8'h06, 1, 1, 0, 0, 1, v, e); check("R3 ceA high", {15'd0, e}, 0); check("R3 zero", v, 0);
    probe(8'h06, 1, 0, 1, 0, 1, v, e); check("R3 ceB high", {15'd0, e}, 0);
    probe(8'h06, 1, 0, 0, 1, 1, v, e); check("R3 oe high", {15'd0, e}, 0);
    probe(8'h06, 1, 0, 0, 0, 0, v, e); check("R3 we low", {15'd0, e}, 0);

    sweepViews(4'b0000);

    // R6, R13, R12: program unlocked, deselected while running
    wr(8'h10, 8'h40);
    lowCount = 0;
    wr(8'h10, 8'h33);
    probe(8'h00, 1, 1, 1, 0, 1, v, e);
    check("R13 deselected outputs off", {15'd0, e}, 0);
    rdChk("R6 busy status", 8'h00, 1, 16'h0000);
    idle(15);
    check("R6 R13 program busy length", 16'(lowCount), 16'(PGM_C));
    rdChk("R6 done status", 8'h00, 1, 16'h0080);

    // R12: command ignored while running
    wr(8'h10, 8'h40);
    wr(8'h10, 8'h34);
    wr(0, 8'h90);
    rdChk("R12 view change ignored while busy", 8'h00, 1, 16'h0000);
    idle(15);

    // R8: lock block 2
    wr(8'h80, 8'h60);
    lowCount = 0;
    wr(8'h80, 8'h01);
    idle(10);
    check("R8 lock busy length", 16'(lowCount), 16'(LOCK_C));
    sweepViews(4'b0100);

    // R9, R10: locked program
    wr(8'h90, 8'h40);
    lowCount = 0;
    wr(8'h90, 8'h55);
    idle(10);
    check("R9 locked program no start", 16'(lowCount), 0);
    rdChk("R9 locked program status", 8'h00, 1, 16'h0092);
    wr(0, 8'h50);
    rdChk("R10 clear status", 8'h00, 1, 16'h0080);

    // R9, R10: locked erase, sticky errors
    wr(8'h80, 8'h20);
    wr(8'h80, 8'hD0);
    rdChk("R9 locked erase status", 8'h00, 1, 16'h00A2);
    wr(0, 8'hFF); wr(0, 8'h70);
    rdChk("R10 error sticky", 8'h00, 1, 16'h00A2);
    wr(0, 8'h50);

    // R7: erase sequence error
    lowCount = 0;
    wr(8'h40, 8'h20);
    wr(8'h40, 8'hFF);
    idle(5);
    check("R7 bad confirm no start", 16'(lowCount), 0);
    rdChk("R7 bad confirm status", 8'h00, 1, 16'h00A0);
    wr(0, 8'h50);

    // R11, R12: erase suspend/resume
    wr(8'h40, 8'h20);
    lowCount = 0;
    wr(8'h40, 8'hD0);
    wr(0, 8'hB0);
    check("R11 R14 readyBusy while suspended", {15'd0, readyBusy}, 1);
    rdChk("R11 erase suspended status", 8'h00, 1, 16'h00C0);
    held = lowCount;
    idle(20);
    check("R11 frozen while suspended", 16'(lowCount), 16'(held));
    wr(0, 8'h90);
    rdChk("R12 view allowed in suspend", 8'h00, 1, MFR);
    wr(0, 8'h40);
    wr(0, 8'h70);
    rdChk("R12 setup ignored in suspend", 8'h00, 1, 16'h00C0);
    wr(0, 8'hD0);
    idle(30);
    check("R11 erase total length", 16'(lowCount), 16'(ERASE_C));
    rdChk("R11 erase done", 8'h00, 1, 16'h0080);

    // R11: program suspend/resume
    wr(8'h20, 8'h40);
    lowCount = 0;
    wr(8'h20, 8'h77);
    wr(0, 8'hB0);
    rdChk("R11 program suspended status", 8'h00, 1, 16'h0084);
    idle(10);
    wr(0, 8'hD0);
    idle(15);
    check("R11 program total length", 16'(lowCount), 16'(PGM_C));

    // R8: clear all locks
    wr(0, 8'h60);
    wr(0, 8'hD0);
    idle(10);
    wr(8'h90, 8'h40);
    lowCount = 0;
    wr(8'h90, 8'h12);
    idle(15);
    check("R8 unlocked program runs", 16'(lowCount), 16'(PGM_C));
    wr(0, 8'h90);
    rdChk("R8 lock bit cleared", 8'h84, 1, 16'h0000);

    // R4: abort erase with reset pin
    wr(8'h40, 8'h20);
    wr(8'h40, 8'hD0);
    idle(2);
    check("R14 busy during erase", {15'd0, readyBusy}, 0);
    @(negedge clk); rp_n = 0; #1;
    check("R4 abort readyBusy", {15'd0, readyBusy}, 1);
    probe(8'h06, 1, 0, 0, 0, 1, v, e);
    check("R4 abort outputs off", {15'd0, e}, 0);
    idle(3);
    @(negedge clk); rp_n = 1;
    idle(WAKE_C + 2);
    check("R4 idle after abort", {15'd0, readyBusy}, 1);
    rdChk("R4 array view after abort", 8'h06, 1, arrModel(8'h06));
    wr(0, 8'h70);
    rdChk("R4 status 80h after abort", 8'h00, 1, 16'h0080);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule